// File: doc/BRIEF.md
# Dual-Core Cluster Power State Controller

This block is the hardware sequencer that moves each core of a two-core cluster into and out of its low-power states, and that switches the L2 cache shared by the cores. Each core presents a requested depth: run, light sleep, voltage retention, register retention or collapse. The controller then steps that core's clock enable, isolation clamp, retention controls and power switch in a fixed order. For the deeper states it first waits for the core's L1 flush engine to report completion. A wake input, or a request to return to run, reverses the steps. The reverse path holds a programmable number of settle cycles after power returns.

The shared L2 has only two power states, on and off. The L2 is flushed, isolated and switched off when every core sits in register retention or collapse. It is brought back before any waking core is released from isolation. The L2 clock can also be gated on its own while the cores run. The cluster shares one clock frequency: the controller selects the highest frequency any core asks for. Each core's voltage request passes through separately.

Top module: `cluster_pwr_ctl`

## Requirements
- R1: After reset every core has clock enable 1, isolation 0, both retention controls 0, power switch 1 and flush request 0. The L2 is powered, not isolated, clocked and has no flush request. The frequency and voltage outputs are 0.
- R2: Request code 1 (light sleep) drops only the core clock enable. Isolation, retention and power stay as in run, and the clock enable returns to 1 on exit.
- R3: Request codes 2, 3 and 4 (voltage retention, register retention, collapse; codes 5 to 7 act as collapse) make these changes in strictly later cycles, in this order: clock enable falls, isolation rises, retention rises (when the state keeps any), power switch falls.
- R4: While powered down, voltage retention holds both register and L1 retention at 1. Register retention holds register retention at 1 and L1 retention at 0. Collapse holds both at 0. Retention is never active without isolation.
- R5: Register retention and collapse raise the core flush request first, with clock and power still on, and proceed only after flush-done. Light sleep and voltage retention never raise the flush request.
- R6: Exit runs in reverse. Power returns first. With the L2 on, isolation stays high for exactly S+2 cycles from the cycle power returns, where S is the settle count. Retention is released before isolation, and the clock is enabled last.
- R7: A wake during an entry sequence, before the power switch opens, returns the core to run without the power switch ever turning off.
- R8: The L2 powers off only when every core is in register retention or collapse and the L2 flush has been acknowledged. The order is flush request, then isolation, then power switch off.
- R9: When a core leaves a powered-down state while the L2 is off, the L2 powers up first. The core's isolation stays high until the L2 is on, which makes S+5 cycles of isolation with power on in total.
- R10: The L2 gate input holds the L2 clock enable at 0 while the L2 is on and the cores run, and it has no effect on L2 power.
- R11: One cycle after a change of the requests, the frequency output is the highest per-core frequency request. Each voltage output follows its own core's request.
- R12: A change of request code while a core is powered down in a retention or collapse state does not alter that core's retention, power or flush outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | NCORE*3 | Per-core requested depth code |
| core_wake | input | NCORE | Per-core wake interrupt |
| core_flush_done | input | NCORE | Per-core L1 flush completion |
| settle_cycles | input | SW | Settle count S after power returns |
| l2_gate | input | 1 | Request to stop the L2 clock |
| l2_flush_ack | input | 1 | L2 flush completion |
| freq_req | input | NCORE*FW | Per-core frequency level request |
| volt_req | input | NCORE*VW | Per-core voltage level request |
| core_clk_en | output | NCORE | Core clock enable |
| core_iso | output | NCORE | Core output isolation clamp |
| core_ret_reg | output | NCORE | Core register retention enable |
| core_ret_l1 | output | NCORE | Core L1 array retention enable |
| core_pwr_en | output | NCORE | Core power switch enable |
| core_flush_req | output | NCORE | Core L1 flush request |
| l2_clk_en | output | 1 | L2 clock enable |
| l2_iso | output | 1 | L2 isolation clamp |
| l2_pwr_en | output | 1 | L2 power switch enable |
| l2_flush_req | output | 1 | L2 flush request |
| freq_sel | output | FW | Shared cluster frequency level |
| volt_sel | output | NCORE*VW | Per-core voltage level |

## Verification
Several rules are checked on every cycle by the assertions. A core with power off is isolated and unclocked, and retention never appears without isolation. A deep state that needs a flush never loses power without a recorded flush-done. The L2 never stays off once a core has left the deep states, and no core drops isolation while the L2 is down. The exact cycle counts cannot be shown that way and rest on the bench's scenarios: the S+2 and S+5 settle windows, the step order, aborts at the flush and isolation steps, and an ignored request change while powered down. The sweep covers every depth on each core under several settle counts.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [2:0] {
    TGT_RUN  = 3'd0,
    TGT_LSLP = 3'd1,
    TGT_VRET = 3'd2,
    TGT_RRET = 3'd3,
    TGT_COLL = 3'd4
  } tgt_e;

  typedef enum logic [3:0] {
    CS_RUN, CS_FLUSH, CS_CLKOFF, CS_SLEEP, CS_ISO,
    CS_RET, CS_OFF, CS_PWRUP, CS_UNRET, CS_UNISO
  } cstate_e;

  typedef enum logic [2:0] {
    LS_ON, LS_FLUSH, LS_ISO, LS_OFF, LS_PWRUP, LS_UNISO
  } l2state_e;

  typedef struct packed {
    logic clk_en;
    logic iso;
    logic ret_reg;
    logic ret_l1;
    logic pwr_en;
    logic flush_req;
  } core_ctl_t;

  // codes above collapse are folded onto collapse
  function automatic tgt_e decode_tgt(input logic [2:0] code);
    return (code >= 3'd4) ? TGT_COLL : tgt_e'(code);
  endfunction

  function automatic logic needs_flush(input tgt_e t);
    return (t == TGT_RRET) || (t == TGT_COLL);
  endfunction

  function automatic logic keeps_regs(input tgt_e t);
    return (t == TGT_VRET) || (t == TGT_RRET);
  endfunction

  function automatic logic keeps_l1(input tgt_e t);
    return (t == TGT_VRET);
  endfunction

  function automatic logic allows_l2_off(input tgt_e t);
    return (t == TGT_RRET) || (t == TGT_COLL);
  endfunction

endpackage

// File: rtl/cpc_settle_timer.sv
module cpc_settle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cpc_core_seq.sv
module cpc_core_seq
  import cpc_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    req_code,
  input  logic          wake,
  input  logic          flush_done,
  input  logic          l2_ready,
  input  logic [SW-1:0] settle,
  output core_ctl_t     ctl,
  output logic          deep_l2
);
  cstate_e st_q, st_n;
  tgt_e    tgt_q, req_t;
  logic    exit_ev, settle_done, flushed_q, in_pwrup;

  assign req_t    = decode_tgt(req_code);
  assign exit_ev  = wake || (req_t == TGT_RUN);
  assign in_pwrup = (st_q == CS_PWRUP);

  cpc_settle_timer #(.W(SW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_pwrup),
    .limit (settle),
    .done  (settle_done)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      CS_RUN:    if (!exit_ev) st_n = needs_flush(req_t) ? CS_FLUSH : CS_CLKOFF;
      CS_FLUSH:  if (exit_ev) st_n = CS_RUN;
                 else if (flush_done) st_n = CS_CLKOFF;
      CS_CLKOFF: if (exit_ev) st_n = CS_RUN;
                 else st_n = (tgt_q == TGT_LSLP) ? CS_SLEEP : CS_ISO;
      CS_SLEEP:  if (exit_ev) st_n = CS_RUN;
      CS_ISO:    st_n = exit_ev ? CS_UNISO : CS_RET;
      CS_RET:    st_n = exit_ev ? CS_UNRET : CS_OFF;
      CS_OFF:    if (exit_ev) st_n = CS_PWRUP;
      CS_PWRUP:  if (settle_done && l2_ready) st_n = CS_UNRET;
      CS_UNRET:  st_n = CS_UNISO;
      CS_UNISO:  st_n = CS_RUN;
      default:   st_n = CS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CS_RUN;
      tgt_q     <= TGT_RUN;
      flushed_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == CS_RUN && st_n != CS_RUN) tgt_q <= req_t;
      if (st_q == CS_RUN) flushed_q <= 1'b0;
      else if (st_q == CS_FLUSH && flush_done) flushed_q <= 1'b1;
    end
  end

  always_comb begin
    ctl = '{clk_en: 1'b1, iso: 1'b0, ret_reg: 1'b0, ret_l1: 1'b0,
            pwr_en: 1'b1, flush_req: 1'b0};
    unique case (st_q)
      CS_RUN:    ;
      CS_FLUSH:  ctl.flush_req = 1'b1;
      CS_CLKOFF, CS_SLEEP, CS_UNISO: ctl.clk_en = 1'b0;
      CS_ISO, CS_UNRET: begin
        ctl.clk_en = 1'b0;
        ctl.iso    = 1'b1;
      end
      CS_RET, CS_PWRUP: begin
        ctl.clk_en  = 1'b0;
        ctl.iso     = 1'b1;
        ctl.ret_reg = keeps_regs(tgt_q);
        ctl.ret_l1  = keeps_l1(tgt_q);
      end
      CS_OFF: begin
        ctl.clk_en  = 1'b0;
        ctl.iso     = 1'b1;
        ctl.ret_reg = keeps_regs(tgt_q);
        ctl.ret_l1  = keeps_l1(tgt_q);
        ctl.pwr_en  = 1'b0;
      end
      default: ;
    endcase
  end

  assign deep_l2 = (st_q == CS_OFF) && allows_l2_off(tgt_q);

  AST_OFF_NEEDS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.pwr_en |-> (ctl.iso && !ctl.clk_en)); // R3
  AST_ISO_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.iso) |-> !ctl.clk_en); // R3
  AST_RET_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ret_reg || ctl.ret_l1) |-> ctl.iso); // R4
  AST_FLUSH_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.pwr_en && needs_flush(tgt_q)) |-> flushed_q); // R5
  AST_PWRUP_HOLDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.pwr_en) |-> (ctl.iso && !ctl.clk_en)); // R6
endmodule

// File: rtl/cpc_l2_seq.sv
module cpc_l2_seq
  import cpc_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          all_deep,
  input  logic          flush_ack,
  input  logic          gate,
  input  logic [SW-1:0] settle,
  output logic          clk_en,
  output logic          iso,
  output logic          pwr_en,
  output logic          flush_req,
  output logic          ready
);
  l2state_e st_q, st_n;
  logic     settle_done, acked_q, in_pwrup;

  assign in_pwrup = (st_q == LS_PWRUP);

  cpc_settle_timer #(.W(SW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_pwrup),
    .limit (settle),
    .done  (settle_done)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      LS_ON:    if (all_deep) st_n = LS_FLUSH;
      LS_FLUSH: if (!all_deep) st_n = LS_ON;
                else if (flush_ack) st_n = LS_ISO;
      LS_ISO:   st_n = all_deep ? LS_OFF : LS_UNISO;
      LS_OFF:   if (!all_deep) st_n = LS_PWRUP;
      LS_PWRUP: if (settle_done) st_n = LS_UNISO;
      LS_UNISO: st_n = LS_ON;
      default:  st_n = LS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LS_ON;
      acked_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == LS_ON) acked_q <= 1'b0;
      else if (st_q == LS_FLUSH && flush_ack) acked_q <= 1'b1;
    end
  end

  assign ready     = (st_q == LS_ON);
  assign flush_req = (st_q == LS_FLUSH);
  assign pwr_en    = (st_q != LS_OFF);
  assign iso       = (st_q == LS_ISO) || (st_q == LS_OFF) || (st_q == LS_PWRUP);
  assign clk_en    = ((st_q == LS_ON) || (st_q == LS_FLUSH)) && !gate;

  AST_L2_OFF_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> $past(all_deep)); // R8
  AST_L2_ACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> acked_q); // R8
  AST_L2_OFF_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (iso && !clk_en)); // R8
endmodule

// File: rtl/cpc_dvfs_arb.sv
module cpc_dvfs_arb #(
  parameter int NCORE = 2,
  parameter int FW    = 4,
  parameter int VW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCORE-1:0][FW-1:0]   freq_req,
  input  logic [NCORE-1:0][VW-1:0]   volt_req,
  output logic [FW-1:0]              freq_sel,
  output logic [NCORE-1:0][VW-1:0]   volt_sel
);
  function automatic logic [FW-1:0] top_freq(input logic [NCORE-1:0][FW-1:0] v);
    logic [FW-1:0] m;
    m = '0;
    for (int i = 0; i < NCORE; i++) if (v[i] > m) m = v[i];
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_sel <= '0;
    else        freq_sel <= top_freq(freq_req);
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_volt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) volt_sel[g] <= '0;
      else        volt_sel[g] <= volt_req[g];
    end
    AST_FREQ_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (freq_sel >= $past(freq_req[g]))); // R11
  end
endmodule

// File: rtl/cluster_pwr_ctl.sv
module cluster_pwr_ctl
  import cpc_pkg::*;
#(
  parameter int NCORE = 2,
  parameter int SW    = 4,
  parameter int FW    = 4,
  parameter int VW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCORE-1:0][2:0]     core_req,
  input  logic [NCORE-1:0]          core_wake,
  input  logic [NCORE-1:0]          core_flush_done,
  input  logic [SW-1:0]             settle_cycles,
  input  logic                      l2_gate,
  input  logic                      l2_flush_ack,
  input  logic [NCORE-1:0][FW-1:0]  freq_req,
  input  logic [NCORE-1:0][VW-1:0]  volt_req,
  output logic [NCORE-1:0]          core_clk_en,
  output logic [NCORE-1:0]          core_iso,
  output logic [NCORE-1:0]          core_ret_reg,
  output logic [NCORE-1:0]          core_ret_l1,
  output logic [NCORE-1:0]          core_pwr_en,
  output logic [NCORE-1:0]          core_flush_req,
  output logic                      l2_clk_en,
  output logic                      l2_iso,
  output logic                      l2_pwr_en,
  output logic                      l2_flush_req,
  output logic [FW-1:0]             freq_sel,
  output logic [NCORE-1:0][VW-1:0]  volt_sel
);
  logic [NCORE-1:0] deep_vec;
  logic             all_deep, l2_ready;

  assign all_deep = &deep_vec;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    core_ctl_t ctl;
    cpc_core_seq #(.SW(SW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_code   (core_req[g]),
      .wake       (core_wake[g]),
      .flush_done (core_flush_done[g]),
      .l2_ready   (l2_ready),
      .settle     (settle_cycles),
      .ctl        (ctl),
      .deep_l2    (deep_vec[g])
    );
    assign core_clk_en[g]    = ctl.clk_en;
    assign core_iso[g]       = ctl.iso;
    assign core_ret_reg[g]   = ctl.ret_reg;
    assign core_ret_l1[g]    = ctl.ret_l1;
    assign core_pwr_en[g]    = ctl.pwr_en;
    assign core_flush_req[g] = ctl.flush_req;

    AST_CORE_WAITS_L2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_iso[g]) |-> (l2_pwr_en && !l2_iso)); // R9
  end

  cpc_l2_seq #(.SW(SW)) u_l2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_deep  (all_deep),
    .flush_ack (l2_flush_ack),
    .gate      (l2_gate),
    .settle    (settle_cycles),
    .clk_en    (l2_clk_en),
    .iso       (l2_iso),
    .pwr_en    (l2_pwr_en),
    .flush_req (l2_flush_req),
    .ready     (l2_ready)
  );

  cpc_dvfs_arb #(.NCORE(NCORE), .FW(FW), .VW(VW)) u_dvfs (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_req (freq_req),
    .volt_req (volt_req),
    .freq_sel (freq_sel),
    .volt_sel (volt_sel)
  );
endmodule

// File: tb/cluster_pwr_ctl_tb.sv
module cluster_pwr_ctl_tb;
  localparam int NCORE = 2, SW = 4, FW = 4, VW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCORE-1:0][2:0]    core_req;
  logic [NCORE-1:0]         core_wake;
  logic [NCORE-1:0]         core_flush_done;
  logic [SW-1:0]            settle_cycles;
  logic                     l2_gate, l2_flush_ack;
  logic [NCORE-1:0][FW-1:0] freq_req;
  logic [NCORE-1:0][VW-1:0] volt_req;
  logic [NCORE-1:0] core_clk_en, core_iso, core_ret_reg, core_ret_l1, core_pwr_en, core_flush_req;
  logic l2_clk_en, l2_iso, l2_pwr_en, l2_flush_req;
  logic [FW-1:0]            freq_sel;
  logic [NCORE-1:0][VW-1:0] volt_sel;

  always #10 clk = ~clk;

  cluster_pwr_ctl #(.NCORE(NCORE), .SW(SW), .FW(FW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_wake(core_wake),
    .core_flush_done(core_flush_done), .settle_cycles(settle_cycles),
    .l2_gate(l2_gate), .l2_flush_ack(l2_flush_ack), .freq_req(freq_req),
    .volt_req(volt_req), .core_clk_en(core_clk_en), .core_iso(core_iso),
    .core_ret_reg(core_ret_reg), .core_ret_l1(core_ret_l1),
    .core_pwr_en(core_pwr_en), .core_flush_req(core_flush_req),
    .l2_clk_en(l2_clk_en), .l2_iso(l2_iso), .l2_pwr_en(l2_pwr_en),
    .l2_flush_req(l2_flush_req), .freq_sel(freq_sel), .volt_sel(volt_sel));

  int nchk = 0, nfail = 0;
  bit auto_flush = 1'b1, auto_l2 = 1'b1;

  // responders for the flush handshakes
  always @(negedge clk) begin
    for (int i = 0; i < NCORE; i++) core_flush_done[i] <= auto_flush & core_flush_req[i];
    l2_flush_ack <= auto_l2 & l2_flush_req;
  end

  // monitor for one core, sampled mid-cycle after each rising edge
  int mc = 0, cyc = 0, wd = 0;
  int t_clk, t_iso, t_ret, t_off, iso_cnt;
  bit saw_flush;
  logic p_clk, p_iso, p_ret, p_pwr;

  task automatic arm(input int c);
    mc = c; t_clk = -1; t_iso = -1; t_ret = -1; t_off = -1;
    iso_cnt = 0; saw_flush = 1'b0;
    p_clk = core_clk_en[c]; p_iso = core_iso[c];
    p_ret = core_ret_reg[c] | core_ret_l1[c]; p_pwr = core_pwr_en[c];
  endtask

  always begin
    @(posedge clk); #5;
    cyc++; wd++;
    if (p_clk && !core_clk_en[mc] && t_clk < 0) t_clk = cyc;
    if (!p_iso && core_iso[mc] && t_iso < 0) t_iso = cyc;
    if (!p_ret && (core_ret_reg[mc] | core_ret_l1[mc]) && t_ret < 0) t_ret = cyc;
    if (p_pwr && !core_pwr_en[mc] && t_off < 0) t_off = cyc;
    if (core_flush_req[mc]) saw_flush = 1'b1;
    if (!core_pwr_en[mc]) iso_cnt = 0;
    else if (core_iso[mc]) iso_cnt++;
    p_clk = core_clk_en[mc]; p_iso = core_iso[mc];
    p_ret = core_ret_reg[mc] | core_ret_l1[mc]; p_pwr = core_pwr_en[mc];
    if (wd > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected <150000 cycles", wd);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rid, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rid, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_run(input int c, input string rid);
    chk(core_clk_en[c] == 1'b1, rid, "clk_en run", core_clk_en[c], 1);
    chk(core_iso[c] == 1'b0, rid, "iso run", core_iso[c], 0);
    chk(core_pwr_en[c] == 1'b1, rid, "pwr_en run", core_pwr_en[c], 1);
    chk((core_ret_reg[c] | core_ret_l1[c]) == 1'b0, rid, "ret run", core_ret_reg[c], 0);
    chk(core_flush_req[c] == 1'b0, rid, "flush_req run", core_flush_req[c], 0);
  endtask

  // one entry and exit of core c into depth t with settle count s
  task automatic run_depth(input int c, input int t, input int s);
    bit exp_rr, exp_rl, exp_fl;
    exp_rr = (t == 2) || (t == 3);
    exp_rl = (t == 2);
    exp_fl = (t >= 3);
    settle_cycles = SW'(s);
    arm(c);
    core_req[c] = 3'(t);
    waitn(30);
    if (t == 1) begin
      chk(core_clk_en[c] == 1'b0, "R2", "sleep clk_en", core_clk_en[c], 0);
      chk(core_iso[c] == 1'b0 && core_pwr_en[c] == 1'b1, "R2", "sleep iso/pwr", core_iso[c], 0);
      chk((core_ret_reg[c] | core_ret_l1[c]) == 1'b0, "R2", "sleep ret", core_ret_reg[c], 0);
      chk(saw_flush == 1'b0, "R5", "sleep flush", saw_flush, 0);
    end else begin
      chk(core_pwr_en[c] == 1'b0, "R3", "pwr_en off", core_pwr_en[c], 0);
      chk(core_iso[c] == 1'b1 && core_clk_en[c] == 1'b0, "R3", "iso/clk off", core_iso[c], 1);
      chk(t_clk >= 0 && t_clk < t_iso, "R3", "clk gate before iso", t_clk, t_iso - 1);
      if (exp_rr) begin
        chk(t_iso < t_ret && t_ret < t_off, "R3", "iso<ret<off", t_ret, t_iso + 1);
      end else begin
        chk(t_iso < t_off && t_ret < 0, "R3", "iso<off no ret", t_off, t_iso + 1);
      end
      chk(core_ret_reg[c] == exp_rr, "R4", "ret_reg", core_ret_reg[c], exp_rr);
      chk(core_ret_l1[c] == exp_rl, "R4", "ret_l1", core_ret_l1[c], exp_rl);
      chk(saw_flush == exp_fl, "R5", "flush requested", saw_flush, exp_fl);
      chk(l2_pwr_en == 1'b1, "R8", "l2 stays on with a core running", l2_pwr_en, 1);
    end
    core_req[c] = 3'd0;
    core_wake[c] = (s == 3);
    waitn(30);
    core_wake[c] = 1'b0;
    chk_run(c, (t == 1) ? "R2" : "R6");
    if (t > 1) chk(iso_cnt == s + 2, "R6", "iso window after power up", iso_cnt, s + 2);
    waitn(2);
  endtask

  initial begin
    rst_n = 1'b0;
    core_req = '0; core_wake = '0; settle_cycles = '0;
    l2_gate = 1'b0; freq_req = '0; volt_req = '0;
    arm(0);
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    for (int c = 0; c < NCORE; c++) chk_run(c, "R1");
    chk(l2_pwr_en && !l2_iso && l2_clk_en && !l2_flush_req, "R1", "l2 reset", l2_pwr_en, 1);
    chk(freq_sel == '0 && volt_sel == '0, "R1", "dvfs reset", freq_sel, 0);

    // R11 frequency and voltage
    freq_req[0] = 4'd5; freq_req[1] = 4'd9; volt_req[0] = 4'd3; volt_req[1] = 4'd11;
    waitn(1);
    chk(freq_sel == 4'd9, "R11", "freq max", freq_sel, 9);
    chk(volt_sel[0] == 4'd3 && volt_sel[1] == 4'd11, "R11", "volt per core", volt_sel[1], 11);
    freq_req[0] = 4'd12; freq_req[1] = 4'd3; volt_req[0] = 4'd15; volt_req[1] = 4'd0;
    waitn(1);
    chk(freq_sel == 4'd12, "R11", "freq max swapped", freq_sel, 12);
    chk(volt_sel[0] == 4'd15 && volt_sel[1] == 4'd0, "R11", "volt follow", volt_sel[0], 15);
    freq_req[0] = 4'd7; freq_req[1] = 4'd7;
    waitn(1);
    chk(freq_sel == 4'd7, "R11", "freq equal", freq_sel, 7);

    // R10 L2 clock gate with cores running
    l2_gate = 1'b1;
    waitn(2);
    chk(l2_clk_en == 1'b0, "R10", "l2 clk gated", l2_clk_en, 0);
    chk(l2_pwr_en == 1'b1 && core_clk_en == 2'b11, "R10", "l2 power kept", l2_pwr_en, 1);
    l2_gate = 1'b0;
    waitn(2);
    chk(l2_clk_en == 1'b1, "R10", "l2 clk restored", l2_clk_en, 1);

    // sweep of every depth on each core under several settle counts
    for (int c = 0; c < NCORE; c++)
      for (int t = 1; t <= 4; t++)
        for (int si = 0; si < 4; si++)
          run_depth(c, t, (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 3 : 7);
    // code 6 acts as collapse
    run_depth(1, 6, 2);

    // R5 and R7: flush stall then abort by wake
    settle_cycles = 4'd1;
    auto_flush = 1'b0;
    arm(0);
    core_req[0] = 3'd3;
    waitn(6);
    chk(core_flush_req[0] == 1'b1, "R5", "flush held", core_flush_req[0], 1);
    chk(core_clk_en[0] && core_pwr_en[0], "R5", "clk/pwr on during flush", core_pwr_en[0], 1);
    core_wake[0] = 1'b1;
    waitn(5);
    chk_run(0, "R7");
    chk(t_off < 0, "R7", "no power off on flush abort", t_off, -1);
    core_req[0] = 3'd0; core_wake[0] = 1'b0; auto_flush = 1'b1;
    waitn(3);

    // R7: abort once isolation is up
    arm(0);
    core_req[0] = 3'd2;
    waitn(2);
    chk(core_iso[0] == 1'b1 && core_pwr_en[0] == 1'b1, "R7", "at iso step", core_iso[0], 1);
    core_wake[0] = 1'b1;
    waitn(6);
    chk_run(0, "R7");
    chk(t_off < 0 && t_ret < 0, "R7", "no ret/off on iso abort", t_off, -1);
    core_req[0] = 3'd0; core_wake[0] = 1'b0;
    waitn(3);

    // R12: request change while in voltage retention
    arm(0);
    core_req[0] = 3'd2;
    waitn(20);
    core_req[0] = 3'd4;
    waitn(10);
    chk(core_ret_l1[0] == 1'b1 && core_ret_reg[0] == 1'b1, "R12", "retention kept", core_ret_l1[0], 1);
    chk(core_pwr_en[0] == 1'b0 && !saw_flush, "R12", "still off no flush", core_pwr_en[0], 0);
    core_req[0] = 3'd0;
    waitn(30);
    chk_run(0, "R12");

    // R8: voltage retention on one core keeps L2 on
    core_req[0] = 3'd3; core_req[1] = 3'd2;
    waitn(30);
    chk(l2_pwr_en == 1'b1 && l2_flush_req == 1'b0, "R8", "l2 on with vret core", l2_pwr_en, 1);
    core_req = '0;
    waitn(30);

    // R8: L2 waits for its flush acknowledge, then turns off
    auto_l2 = 1'b0;
    core_req[0] = 3'd3; core_req[1] = 3'd4;
    waitn(30);
    chk(l2_flush_req == 1'b1 && l2_pwr_en == 1'b1, "R8", "l2 waits ack", l2_pwr_en, 1);
    auto_l2 = 1'b1;
    waitn(10);
    chk(l2_pwr_en == 1'b0 && l2_iso == 1'b1, "R8", "l2 off", l2_pwr_en, 0);
    chk(l2_clk_en == 1'b0, "R8", "l2 clock off", l2_clk_en, 0);

    // R9: wake core 0 with L2 off
    settle_cycles = 4'd2;
    arm(0);
    core_req[0] = 3'd0;
    waitn(40);
    chk_run(0, "R9");
    chk(iso_cnt == 2 + 5, "R9", "iso window with l2 power up", iso_cnt, 7);
    chk(l2_pwr_en == 1'b1 && l2_iso == 1'b0, "R9", "l2 back on", l2_pwr_en, 1);
    chk(core_pwr_en[1] == 1'b0, "R9", "other core stays off", core_pwr_en[1], 0);
    core_req[1] = 3'd0;
    waitn(40);
    chk_run(1, "R9");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule